// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is an I2C bus slave that lets an external host reach a bank of byte-wide registers. It watches SCL and SDA, which must already be synchronised to the system clock. It finds START and STOP conditions on the bus and compares the first byte of each transaction against its own 7-bit device address. The block never drives SDA high. It pulls the line low through an active-high enable, and a pad outside the block turns that enable into open-drain behaviour.

The device address is assembled from three parts. The two top bits are fixed at 1. Four configuration inputs fill the middle bits, and a single strap pin gives the lowest bit. A write transaction works as follows. The first byte after the address loads an internal register pointer. Each later byte is stored at the pointer, and the pointer then advances. A read works in two transactions. A write transaction first sets the pointer. A new transaction with the read bit set then streams bytes from the pointer, for as long as the master acknowledges each one. The block also answers the all-zero general-call address and captures the command byte that follows it. The register file sits outside the block and is reached through a single-cycle strobe port. Reads must be combinational.

The block's state machine has eight states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: the address byte is being shifted in.
- `ST_ADDR_ACK`: the ninth clock of the address byte.
- `ST_RX`: a pointer, data or command byte is being received.
- `ST_RX_ACK`: the acknowledge clock of a received byte.
- `ST_TX`: a data byte is being sent to the master.
- `ST_TX_ACK`: the master's acknowledge clock.
- `ST_IGNORE`: the block stays silent until the bus is reset.

The transitions are:
- Any state goes to ST_ADDR on a START.
- Any state goes to ST_IDLE on a STOP.
- ST_ADDR goes to ST_ADDR_ACK when the address matches. It goes to ST_IGNORE when it does not.
- ST_ADDR_ACK goes to ST_TX for a read and to ST_RX for a write.
- ST_RX goes to ST_RX_ACK after eight bits.
- ST_RX_ACK goes back to ST_RX. After a general-call command byte it goes to ST_IGNORE instead.
- ST_TX goes to ST_TX_ACK after eight bits.
- ST_TX_ACK goes to ST_TX when the master acknowledges. It goes to ST_IGNORE when the master does not.

Top module: `i2c_regslave`

## Requirements
- R1: The device address is {1, 1, cfg_addr[3], cfg_addr[2], cfg_addr[1], cfg_addr[0], strap_addr}. It is compared with bits 7..1 of the first byte after START, and bit 0 of that byte is the direction (0 = master writes, 1 = master reads). On a match, the slave acknowledges by asserting sda_oe through the ninth SCL clock.
- R2: On an address mismatch, the slave leaves sda_oe low and raises no register strobe until the next START or STOP, whatever the master sends.
- R3: The address 7'b0000000 with bit 0 = 0 is acknowledged. The byte that follows is acknowledged and appears on gc_cmd, and gc_valid pulses for one cycle. The same address with bit 0 = 1 is not acknowledged.
- R4: In a write transaction, the first byte after the address loads the register pointer. Each following byte raises reg_we for one cycle, with reg_addr set to the pointer and reg_wdata set to the byte. Every received byte is acknowledged.
- R5: The pointer advances by one after each byte written or read. It wraps from all-ones to zero.
- R6: In a read transaction, bytes go out MSB first, starting at the pointer. Each byte is fetched with a one-cycle reg_re pulse. sda_oe changes only while SCL is low.
- R7: A master ACK (SDA low on the ninth clock) makes the slave fetch and send the next byte. A master NACK ends the transfer: the slave releases SDA and fetches nothing more until the next START or STOP.
- R8: A START (SDA falling while SCL is high) at any point, including in the middle of a byte, discards any partial byte. The next eight bits are then taken as an address byte.
- R9: A START followed directly by a STOP (SDA rising while SCL is high) causes no register strobe and leaves sda_oe low.
- R10: After reset, sda_oe, reg_we, reg_re and gc_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| cfg_addr | input | PROG_W (4) | Programmable device-address bits |
| strap_addr | input | 1 | Strap-pin address bit (address LSB) |
| reg_addr | output | PTR_W (8) | Register pointer / access address |
| reg_wdata | output | 8 | Byte to store |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read-fetch strobe |
| reg_rdata | input | 8 | Register content at reg_addr (combinational) |
| gc_cmd | output | 8 | Last general-call command byte |
| gc_valid | output | 1 | One-cycle pulse after gc_cmd updates |

## Verification
The block sees an SCL falling edge in the same cycle the low level arrives. In that cycle, reg_we and reg_re are high together with the edge, and sda_oe takes its new value one clock later. The bench therefore changes its inputs just after a rising clock edge. It counts strobes and updates its register model at the following falling edge. It holds each SCL phase for four clocks, so every acknowledge or data bit has settled long before it is sampled two clocks into the high phase. gc_valid comes one cycle after the command byte completes and is counted the same way. Register contents are compared only after the STOP of the transaction that wrote them.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_IGNORE
    } st_e;

    typedef enum logic [1:0] {
        RK_PTR, RK_DATA, RK_GC
    } rx_kind_e;
endpackage

// File: rtl/i2c_rs_cond.sv
// Bus-condition detector: SCL edges plus START/STOP from one cycle of history.
module i2c_rs_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_rs_match.sv
// Address comparator: fixed ones, programmable bits, strap bit.
module i2c_rs_match #(
    parameter int PROG_W = 4
) (
    input  logic [6:0]        addr7,
    input  logic [PROG_W-1:0] prog,
    input  logic              hw,
    output logic              own_hit,
    output logic              gc_hit
);
    localparam int FIX_W = 6 - PROG_W;

    logic [6:0] own_addr;
    assign own_addr = {{FIX_W{1'b1}}, prog, hw};
    assign own_hit  = (addr7 == own_addr);
    assign gc_hit   = (addr7 == 7'd0);
endmodule

// File: rtl/i2c_rs_fsm.sv
// Protocol state machine and byte datapath.
module i2c_rs_fsm
    import i2c_rs_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_i,
    input  logic              own_hit,
    input  logic              gc_hit,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    output logic [BYTE_W-1:0] gc_cmd,
    output logic              gc_valid,
    output st_e               st_o
);
    st_e              st, st_n;
    rx_kind_e         kind;
    logic [CNT_W-1:0] cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh, gc_q;
    logic [PTR_W-1:0] ptr;
    logic             rw, is_gc, mack, gcv_q;
    logic             byte_done;

    assign byte_done = (cnt == CNT_W'(BYTE_W)) && scl_fall;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // next state
    always_comb begin
        st_n = st;
        if (start_det) begin
            st_n = ST_ADDR;
        end else if (stop_det) begin
            st_n = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:     st_n = ST_IDLE;
                ST_ADDR:     if (byte_done)
                                 st_n = (own_hit || (gc_hit && !rx_sh[0])) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) st_n = rw ? ST_TX : ST_RX;
                ST_RX:       if (byte_done) st_n = ST_RX_ACK;
                ST_RX_ACK:   if (scl_fall) st_n = (kind == RK_GC) ? ST_IGNORE : ST_RX;
                ST_TX:       if (scl_fall && cnt == CNT_W'(BYTE_W - 1)) st_n = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) st_n = mack ? ST_TX : ST_IGNORE;
                ST_IGNORE:   st_n = ST_IGNORE;
                default:     st_n = ST_IDLE;
            endcase
        end
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind  <= RK_PTR;
            cnt   <= '0;
            rx_sh <= '0;
            tx_sh <= '0;
            gc_q  <= '0;
            ptr   <= '0;
            rw    <= 1'b0;
            is_gc <= 1'b0;
            mack  <= 1'b0;
            gcv_q <= 1'b0;
        end else begin
            gcv_q <= 1'b0;
            if (start_det) begin
                cnt <= '0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_RX: begin
                        if (scl_rise) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], sda_i};
                            cnt   <= cnt + CNT_W'(1);
                        end
                        if (byte_done && st == ST_ADDR) begin
                            rw    <= rx_sh[0];
                            is_gc <= !own_hit;
                        end
                        if (byte_done && st == ST_RX) begin
                            unique case (kind)
                                RK_PTR:  ptr <= PTR_W'(rx_sh);
                                RK_DATA: ptr <= ptr + PTR_W'(1);
                                RK_GC: begin
                                    gc_q  <= rx_sh;
                                    gcv_q <= 1'b1;
                                end
                                default: ;
                            endcase
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            tx_sh <= reg_rdata;
                            ptr   <= ptr + PTR_W'(1);
                        end else begin
                            kind <= is_gc ? RK_GC : RK_PTR;
                        end
                    end
                    ST_RX_ACK: if (scl_fall) begin
                        cnt <= '0;
                        if (kind == RK_PTR) kind <= RK_DATA;
                    end
                    ST_TX: if (scl_fall) begin
                        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                        cnt   <= cnt + CNT_W'(1);
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) mack <= !sda_i;
                        if (scl_fall && mack) begin
                            tx_sh <= reg_rdata;
                            ptr   <= ptr + PTR_W'(1);
                            cnt   <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        unique case (st)
            ST_ADDR_ACK, ST_RX_ACK: sda_oe = 1'b1;
            ST_TX:                  sda_oe = !tx_sh[BYTE_W-1];
            default:                sda_oe = 1'b0;
        endcase
        reg_we    = (st == ST_RX) && (kind == RK_DATA) && byte_done;
        reg_re    = scl_fall && (((st == ST_ADDR_ACK) && rw) || ((st == ST_TX_ACK) && mack));
        reg_addr  = ptr;
        reg_wdata = rx_sh;
        gc_cmd    = gc_q;
        gc_valid  = gcv_q;
        rx_byte   = rx_sh;
        st_o      = st;
    end
endmodule

// File: rtl/i2c_regslave.sv
// Top: I2C slave giving pointer-based access to an external register file.
module i2c_regslave #(
    parameter int PTR_W  = 8,
    parameter int PROG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [PROG_W-1:0] cfg_addr,
    input  logic              strap_addr,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [7:0]        reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [7:0]        reg_rdata,
    output logic [7:0]        gc_cmd,
    output logic              gc_valid
);
    logic scl_rise_w, scl_fall_w, start_w, stop_w;
    logic own_hit_w, gc_hit_w;
    logic [7:0] rx_byte_w;
    i2c_rs_pkg::st_e fsm_st;

    i2c_rs_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .start_det (start_w),
        .stop_det  (stop_w)
    );

    i2c_rs_match #(.PROG_W(PROG_W)) u_match (
        .addr7   (rx_byte_w[7:1]),
        .prog    (cfg_addr),
        .hw      (strap_addr),
        .own_hit (own_hit_w),
        .gc_hit  (gc_hit_w)
    );

    i2c_rs_fsm #(.PTR_W(PTR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .start_det (start_w),
        .stop_det  (stop_w),
        .sda_i     (sda_i),
        .own_hit   (own_hit_w),
        .gc_hit    (gc_hit_w),
        .reg_rdata (reg_rdata),
        .rx_byte   (rx_byte_w),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .gc_cmd    (gc_cmd),
        .gc_valid  (gc_valid),
        .st_o      (fsm_st)
    );
endmodule

// File: rtl/i2c_regslave_chk.sv
// Protocol checker, bound into the top module.
module i2c_regslave_chk
    import i2c_rs_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             start_det,
    input logic             stop_det,
    input logic             sda_oe,
    input logic             reg_we,
    input logic             reg_re,
    input logic [PTR_W-1:0] reg_addr,
    input logic             gc_valid,
    input st_e              st
);
    // R6: the pull-down enable only moves while SCL is low
    p_oe_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_i) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    // R6: a fetch always leads into sending a byte
    p_fetch_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> (st == ST_TX));

    // R4: write and fetch never coincide
    p_we_re_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));

    // R5: pointer steps after a write
    p_we_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == $past(reg_addr) + PTR_W'(1)));

    // R5: pointer steps after a fetch
    p_re_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> (reg_addr == $past(reg_addr) + PTR_W'(1)));

    // R8: START always restarts address reception
    p_start_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_ADDR));

    // R9: STOP returns to idle with the line released
    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE && !sda_oe));

    // R3: general-call notification is a single-cycle pulse
    p_gc_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gc_valid |=> !gc_valid);
endmodule

bind i2c_regslave i2c_regslave_chk #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .start_det (start_w),
    .stop_det  (stop_w),
    .sda_oe    (sda_oe),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_addr  (reg_addr),
    .gc_valid  (gc_valid),
    .st        (fsm_st)
);

// File: tb/i2c_regslave_bench.sv
`timescale 1ns/1ps
module i2c_regslave_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [3:0] prog = 4'b1010;
    logic       hw = 1'b1;
    logic       sda_oe;
    logic [7:0] reg_addr, reg_wdata, reg_rdata, gc_cmd;
    logic       reg_we, reg_re, gc_valid;
    logic       sda_line;

    logic [7:0] mem     [256];
    logic [7:0] exp_mem [256];

    int n_chk = 0, n_bad = 0;
    int we_cnt = 0, re_cnt = 0, gcv_cnt = 0, hi_chg = 0;
    bit done = 0;
    logic prev_scl = 1'b1, prev_oe = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    assign sda_line  = m_sda & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    i2c_regslave u_i2c_regslave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .cfg_addr   (prog),
        .strap_addr (hw),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we),
        .reg_re     (reg_re),
        .reg_rdata  (reg_rdata),
        .gc_cmd     (gc_cmd),
        .gc_valid   (gc_valid)
    );

    // register-file model and strobe counters, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                mem[reg_addr] = reg_wdata;
                we_cnt++;
            end
            if (reg_re) re_cnt++;
            if (gc_valid) gcv_cnt++;
            if (m_scl && prev_scl && (sda_oe != prev_oe)) hi_chg++;
        end
        prev_scl = m_scl;
        prev_oe  = sda_oe;
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic hp();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; hp();
        m_scl = 1'b1; hp();
        m_sda = 1'b0; hp();
        m_scl = 1'b0; hp();
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; hp();
        m_scl = 1'b1; hp();
        m_sda = 1'b1; hp();
    endtask

    task automatic wbit(input logic b);
        m_sda = b;    hp();
        m_scl = 1'b1; hp();
        m_scl = 1'b0; hp();
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; hp();
        m_scl = 1'b1;
        repeat (2) @(negedge clk);
        b = sda_line;
        repeat (2) @(posedge clk);
        #1;
        m_scl = 1'b0; hp();
    endtask

    task automatic wbyte(input logic [7:0] v, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        ack = !a;
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        wbit(give_ack ? 1'b0 : 1'b1);
    endtask

    // {pad, addr7, expect_ack, ptr, data}
    localparam logic [31:0] VEC [4] = '{
        {8'h00, 7'h75, 1'b1, 8'h10, 8'hA5},
        {8'h00, 7'h74, 1'b0, 8'h11, 8'h5A},
        {8'h00, 7'h35, 1'b0, 8'h12, 8'h33},
        {8'h00, 7'h75, 1'b1, 8'hFF, 8'h3C}
    };

    initial begin
        bit ack, ack2, ack3;
        logic [7:0] d;
        logic b;
        int we0, re0, gc0;

        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i) ^ 8'hC3;
            exp_mem[i] = 8'(i) ^ 8'hC3;
        end
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10", sda_oe, 0, "sda_oe after reset");
        check("R10", reg_we, 0, "reg_we after reset");
        check("R10", reg_re, 0, "reg_re after reset");
        check("R10", gc_valid, 0, "gc_valid after reset");
        hp();

        // table: own address (cfg 1010, strap 1 -> 7'h75) and mismatches (R1, R2, R4)
        for (int i = 0; i < 4; i++) begin
            logic [31:0] v;
            v = VEC[i];
            we0 = we_cnt;
            i2c_start();
            wbyte({v[23:17], 1'b0}, ack);
            check(v[16] ? "R1" : "R2", ack, v[16], "address ack");
            wbyte(v[15:8], ack2);
            wbyte(v[7:0], ack3);
            i2c_stop();
            if (v[16]) exp_mem[v[15:8]] = v[7:0];
            check(v[16] ? "R4" : "R2", mem[v[15:8]], exp_mem[v[15:8]], "stored byte");
            check(v[16] ? "R4" : "R2", we_cnt - we0, v[16] ? 1 : 0, "write strobes");
            if (v[16]) check("R4", ack2 & ack3, 1, "data acks");
            hp();
        end

        // burst write across the pointer wrap (R4, R5)
        we0 = we_cnt;
        i2c_start();
        wbyte(8'hEA, ack);
        wbyte(8'hFE, ack);
        wbyte(8'h11, ack);
        wbyte(8'h22, ack);
        wbyte(8'h33, ack2);
        i2c_stop();
        exp_mem[8'hFE] = 8'h11; exp_mem[8'hFF] = 8'h22; exp_mem[8'h00] = 8'h33;
        check("R5", mem[8'hFE], 8'h11, "burst byte 0");
        check("R5", mem[8'hFF], 8'h22, "burst byte 1");
        check("R5", mem[8'h00], 8'h33, "burst byte 2 after wrap");
        check("R4", we_cnt - we0, 3, "burst strobes");
        hp();

        // pointer set, repeated start, read three bytes (R6, R7)
        re0 = re_cnt;
        i2c_start();
        wbyte(8'hEA, ack);
        wbyte(8'hFE, ack);
        i2c_start();
        wbyte(8'hEB, ack);
        check("R1", ack, 1, "read address ack");
        rbyte(1'b1, d); check("R6", d, 8'h11, "read byte 0");
        rbyte(1'b1, d); check("R6", d, 8'h22, "read byte 1");
        rbyte(1'b0, d); check("R6", d, 8'h33, "read byte 2");
        rbit(b); check("R7", b, 1, "line released after NACK bit 0");
        rbit(b); check("R7", b, 1, "line released after NACK bit 1");
        check("R7", re_cnt - re0, 3, "fetches stop at NACK");
        i2c_stop();
        hp();

        // read continues from the advanced pointer (R5)
        i2c_start();
        wbyte(8'hEB, ack);
        rbyte(1'b0, d);
        i2c_stop();
        check("R5", d, exp_mem[8'h01], "read after wrap continues");
        hp();

        // general call (R3)
        we0 = we_cnt; gc0 = gcv_cnt;
        i2c_start();
        wbyte(8'h00, ack);
        wbyte(8'h06, ack2);
        i2c_stop();
        check("R3", ack, 1, "general call ack");
        check("R3", ack2, 1, "general call command ack");
        check("R3", gc_cmd, 8'h06, "captured command");
        check("R3", gcv_cnt - gc0, 1, "gc_valid pulses");
        check("R3", we_cnt - we0, 0, "no register write on general call");
        i2c_start();
        wbyte(8'h01, ack);
        i2c_stop();
        check("R3", ack, 0, "general call with read bit");
        hp();

        // START in mid-byte (R8)
        we0 = we_cnt;
        i2c_start();
        wbyte(8'hEA, ack);
        wbyte(8'h30, ack);
        wbit(1'b1); wbit(1'b0); wbit(1'b1);
        i2c_start();
        wbyte(8'hEA, ack);
        check("R8", ack, 1, "address after restart");
        wbyte(8'h40, ack);
        wbyte(8'h77, ack);
        i2c_stop();
        exp_mem[8'h40] = 8'h77;
        check("R8", mem[8'h30], exp_mem[8'h30], "partial byte discarded");
        check("R8", mem[8'h40], 8'h77, "write after restart");
        check("R8", we_cnt - we0, 1, "single write strobe");
        hp();

        // void message (R9)
        we0 = we_cnt; re0 = re_cnt;
        i2c_start();
        i2c_stop();
        check("R9", sda_oe, 0, "line released after void message");
        check("R9", (we_cnt - we0) + (re_cnt - re0), 0, "no access on void message");
        i2c_start();
        wbyte(8'hEA, ack);
        wbyte(8'h50, ack);
        wbyte(8'h99, ack);
        i2c_stop();
        exp_mem[8'h50] = 8'h99;
        check("R9", mem[8'h50], 8'h99, "normal write after void message");
        hp();

        // address inputs (R1)
        hw = 1'b0;
        i2c_start();
        wbyte(8'hEA, ack);
        i2c_stop();
        check("R1", ack, 0, "strap 0 rejects 7'h75");
        i2c_start();
        wbyte(8'hE8, ack);
        wbyte(8'h60, ack2);
        wbyte(8'h42, ack3);
        i2c_stop();
        exp_mem[8'h60] = 8'h42;
        check("R1", ack, 1, "strap 0 accepts 7'h74");
        check("R1", mem[8'h60], 8'h42, "write via strap-0 address");
        prog = 4'b0101; hw = 1'b1;
        i2c_start();
        wbyte(8'hD6, ack);
        i2c_stop();
        check("R1", ack, 1, "cfg 0101 strap 1 accepts 7'h6B");

        check("R6", hi_chg, 0, "sda_oe changes while SCL high");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule